// File: doc/BRIEF.md
# Delay-Buffer DRAM Address and Refresh Unit

This unit forms DRAM physical addresses for a set of circular audio delay buffers. Each buffer owns a base register. A granted access puts that register on the address output and then advances it by one. The low bits of every physical address act as the DRAM row number. Sequential delay-line traffic therefore sweeps the rows and refreshes them with no extra cycles. After reset the buffers start at evenly spaced row offsets, so that together they cover the whole row space in a fraction of the time one buffer would need.

When the processor is halted for debug, normal buffer traffic stops and rows would age out. If software has set the refresh-enable bit in the control register, an internal programmable down-counter then takes over. Each time it expires it issues one refresh cycle for the next row of a wrapping row counter. Access strobes and refresh strobes are mutually exclusive, and all outputs come straight from registers.

Top module: `dlbuf_dram_agu`

## Requirements
- R1: After reset `acc_stb`, `ref_stb`, `phys_addr`, `row_addr` and `acc_buf` are zero. Buffer i's base register holds i*(2^ROW_W/NUM_BUF), which is 0x000 and 0x100 for the default of two buffers with 9 row bits.
- R2: A request on `acc_req[i]` sampled at a clock edge while `dbg_halt` and `base_wr` are low produces, after that edge, `acc_stb`=1, `acc_buf`=i, `phys_addr` equal to buffer i's base before the access, and `row_addr` equal to its low ROW_W bits.
- R3: Every granted access increments that buffer's base register by one, modulo 2^ADDR_W, so 0x3FFFF is followed by 0 for ADDR_W=18.
- R4: When several buffers request in the same cycle, only the lowest index is granted. The other buffers' requests are dropped and their bases do not change.
- R5: `base_wr` loads `base_wdata` into the base selected by `base_sel`. No access is granted in a cycle where `base_wr` is high.
- R6: While `dbg_halt` is high, requests are ignored. `acc_stb` stays low and no base register changes.
- R7: `ref_stb` is only raised after cycles in which `dbg_halt` is high and the stored refresh-enable bit is 1. A refresh drives `row_addr` with the refresh row and `phys_addr` with that row zero-extended.
- R8: With a stored period P, the first refresh strobe follows P+1 active cycles and later strobes come every P+1 cycles. The counter reloads P whenever refresh is inactive. A `cfg_wr` updates the enable bit and P at the next edge.
- R9: The refresh row counter starts at 0 and advances by one per refresh. It wraps from 2^ROW_W-1 to 0 and keeps its value across debug sessions.
- R10: `acc_stb` and `ref_stb` are never high in the same cycle.
- R11: From the reset offsets, 2^ROW_W/NUM_BUF sequential accesses to each buffer visit every row. 2^ROW_W consecutive timer refreshes also visit every row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | NUM_BUF | Per-buffer access request |
| dbg_halt | input | 1 | Processor halted for debug |
| base_wr | input | 1 | Load a base register |
| base_sel | input | IDX_W | Buffer whose base is loaded |
| base_wdata | input | ADDR_W | New base value |
| cfg_wr | input | 1 | Load the refresh control register |
| cfg_ref_en | input | 1 | Refresh-enable bit value |
| cfg_period | input | TMR_W | Refresh timer period value |
| acc_stb | output | 1 | Access cycle strobe |
| acc_buf | output | IDX_W | Index of the buffer accessed |
| ref_stb | output | 1 | Refresh cycle strobe |
| phys_addr | output | ADDR_W | Physical address |
| row_addr | output | ROW_W | DRAM row address |

## Verification
The bench targets the priority cases: simultaneous requests, a base load colliding with a request, and requests held during debug halt. A wrong arbiter would bump two bases or report the wrong buffer, and a wrong debug gate would raise an access strobe and corrupt a delay line. It checks the base wrap at the top of the address space and the refresh row wrap from 511 to 0, where an off-by-one or a narrow counter would skip or repeat rows. It measures the refresh spacing to the cycle, and a timer that reloaded P-1 or failed to reload would show the wrong interval. Row coverage is checked both for interleaved buffer traffic and for timer refresh, together with the rule that the two strobes never overlap and that refresh row numbering carries on into a second debug session.

// File: rtl/dlbuf_pkg.sv
package dlbuf_pkg;

  // Which event drives the output registers in a given cycle.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ACC  = 2'd1,
    SRC_REF  = 2'd2
  } out_src_e;

endpackage

// File: rtl/dlbuf_base_bank.sv
module dlbuf_base_bank #(
  parameter int NUM_BUF = 2,
  parameter int ADDR_W  = 18,
  parameter int ROW_W   = 9,
  parameter int IDX_W   = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUF-1:0] acc_req,
  input  logic               dbg_halt,
  input  logic               base_wr,
  input  logic [IDX_W-1:0]   base_sel,
  input  logic [ADDR_W-1:0]  base_wdata,
  output logic               grant_v,
  output logic [IDX_W-1:0]   grant_idx,
  output logic [ADDR_W-1:0]  grant_addr
);

  // Row-space slice between neighbouring reset offsets.
  localparam int ROWS = 1 << ROW_W;
  localparam int SPAN = ROWS / NUM_BUF;

  logic [ADDR_W-1:0]  base_q [NUM_BUF];
  logic [NUM_BUF-1:0] grant_oh;
  logic [IDX_W-1:0]   pick;

  // Fixed priority: the lowest requesting index wins.
  always_comb begin
    pick = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (acc_req[i]) pick = IDX_W'(i);
    end
  end

  assign grant_v    = (|acc_req) && !dbg_halt && !base_wr;
  assign grant_idx  = pick;
  assign grant_addr = base_q[pick];

  always_comb begin
    grant_oh = '0;
    if (grant_v) grant_oh[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_BUF; i++) begin
      if (rst) begin
        base_q[i] <= ADDR_W'(i * SPAN);
      end else if (base_wr && (base_sel == IDX_W'(i))) begin
        base_q[i] <= base_wdata;
      end else if (grant_oh[i]) begin
        base_q[i] <= base_q[i] + ADDR_W'(1);
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_oh)); // R4

endmodule

// File: rtl/dlbuf_ref_timer.sv
module dlbuf_ref_timer #(
  parameter int ROW_W      = 9,
  parameter int TMR_W      = 16,
  parameter int DEF_PERIOD = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dbg_halt,
  input  logic             cfg_wr,
  input  logic             cfg_ref_en,
  input  logic [TMR_W-1:0] cfg_period,
  output logic             fire,
  output logic [ROW_W-1:0] ref_row
);

  logic             en_q;
  logic [TMR_W-1:0] per_q;
  logic [TMR_W-1:0] cnt_q;
  logic             active;

  assign active = dbg_halt && en_q;
  assign fire   = active && (cnt_q == '0);

  // Control register: enable bit and reload period.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      per_q <= TMR_W'(DEF_PERIOD);
    end else if (cfg_wr) begin
      en_q  <= cfg_ref_en;
      per_q <= cfg_period;
    end
  end

  // Down-counter held at the period until refresh becomes active.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= TMR_W'(DEF_PERIOD);
    end else if (!active || (cnt_q == '0)) begin
      cnt_q <= per_q;
    end else begin
      cnt_q <= cnt_q - TMR_W'(1);
    end
  end

  // Row counter, wraps naturally at 2^ROW_W.
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_row <= '0;
    end else if (fire) begin
      ref_row <= ref_row + ROW_W'(1);
    end
  end

  AST_REF_SPACING: assert property (@(posedge clk) disable iff (rst)
    (fire && (per_q != '0)) |=> !fire); // R8

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(ref_row)); // R9

endmodule

// File: rtl/dlbuf_out_reg.sv
module dlbuf_out_reg
  import dlbuf_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int ROW_W  = 9,
  parameter int IDX_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  out_src_e          src,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [ROW_W-1:0]  ref_row,
  output logic              acc_stb,
  output logic [IDX_W-1:0]  acc_buf,
  output logic              ref_stb,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [ROW_W-1:0]  row_addr
);

  localparam int HI_W = ADDR_W - ROW_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_stb   <= 1'b0;
      ref_stb   <= 1'b0;
      acc_buf   <= '0;
      phys_addr <= '0;
      row_addr  <= '0;
    end else begin
      acc_stb <= (src == SRC_ACC);
      ref_stb <= (src == SRC_REF);
      case (src)
        SRC_ACC: begin
          acc_buf   <= acc_idx;
          phys_addr <= acc_addr;
          row_addr  <= acc_addr[ROW_W-1:0];
        end
        SRC_REF: begin
          phys_addr <= {{HI_W{1'b0}}, ref_row};
          row_addr  <= ref_row;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dlbuf_dram_agu.sv
module dlbuf_dram_agu
  import dlbuf_pkg::*;
#(
  parameter int NUM_BUF    = 2,
  parameter int ADDR_W     = 18,
  parameter int ROW_W      = 9,
  parameter int TMR_W      = 16,
  parameter int DEF_PERIOD = 255,
  parameter int IDX_W      = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUF-1:0] acc_req,
  input  logic               dbg_halt,
  input  logic               base_wr,
  input  logic [IDX_W-1:0]   base_sel,
  input  logic [ADDR_W-1:0]  base_wdata,
  input  logic               cfg_wr,
  input  logic               cfg_ref_en,
  input  logic [TMR_W-1:0]   cfg_period,
  output logic               acc_stb,
  output logic [IDX_W-1:0]   acc_buf,
  output logic               ref_stb,
  output logic [ADDR_W-1:0]  phys_addr,
  output logic [ROW_W-1:0]   row_addr
);

  logic              grant_v;
  logic [IDX_W-1:0]  grant_idx;
  logic [ADDR_W-1:0] grant_addr;
  logic              fire;
  logic [ROW_W-1:0]  ref_row;
  out_src_e          src;

  dlbuf_base_bank #(
    .NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W), .ROW_W(ROW_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst(rst), .acc_req(acc_req), .dbg_halt(dbg_halt),
    .base_wr(base_wr), .base_sel(base_sel), .base_wdata(base_wdata),
    .grant_v(grant_v), .grant_idx(grant_idx), .grant_addr(grant_addr)
  );

  dlbuf_ref_timer #(
    .ROW_W(ROW_W), .TMR_W(TMR_W), .DEF_PERIOD(DEF_PERIOD)
  ) u_timer (
    .clk(clk), .rst(rst), .dbg_halt(dbg_halt), .cfg_wr(cfg_wr),
    .cfg_ref_en(cfg_ref_en), .cfg_period(cfg_period),
    .fire(fire), .ref_row(ref_row)
  );

  always_comb begin
    if (grant_v)   src = SRC_ACC;
    else if (fire) src = SRC_REF;
    else           src = SRC_NONE;
  end

  dlbuf_out_reg #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .IDX_W(IDX_W)
  ) u_out (
    .clk(clk), .rst(rst), .src(src), .acc_addr(grant_addr),
    .acc_idx(grant_idx), .ref_row(ref_row), .acc_stb(acc_stb),
    .acc_buf(acc_buf), .ref_stb(ref_stb), .phys_addr(phys_addr),
    .row_addr(row_addr)
  );

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(acc_stb && ref_stb)); // R10

  AST_DBG_NO_ACC: assert property (@(posedge clk) disable iff (rst)
    dbg_halt |=> !acc_stb); // R6

  AST_REF_ONLY_DBG: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_stb) |-> $past(dbg_halt)); // R7

  AST_REF_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ref_stb |-> (phys_addr[ADDR_W-1:ROW_W] == '0)); // R7

  AST_ROW_MATCH: assert property (@(posedge clk) disable iff (rst)
    acc_stb |-> (row_addr == phys_addr[ROW_W-1:0])); // R2

endmodule

// File: tb/tb_dlbuf_dram_agu.sv
module tb_dlbuf_dram_agu;

  localparam int NB  = 2;
  localparam int AW  = 18;
  localparam int RW  = 9;
  localparam int TW  = 16;
  localparam int IW  = 1;
  localparam int NROW = 1 << RW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB-1:0] acc_req = '0;
  logic          dbg_halt = 1'b0;
  logic          base_wr = 1'b0;
  logic [IW-1:0] base_sel = '0;
  logic [AW-1:0] base_wdata = '0;
  logic          cfg_wr = 1'b0;
  logic          cfg_ref_en = 1'b0;
  logic [TW-1:0] cfg_period = '0;
  logic          acc_stb;
  logic [IW-1:0] acc_buf;
  logic          ref_stb;
  logic [AW-1:0] phys_addr;
  logic [RW-1:0] row_addr;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [AW-1:0] mdl [NB];
  logic [RW-1:0] exp_row = '0;
  bit seen [NROW];

  always #2 clk = ~clk;

  dlbuf_dram_agu #(.NUM_BUF(NB), .ADDR_W(AW), .ROW_W(RW), .TMR_W(TW)) dut (
    .clk(clk), .rst(rst), .acc_req(acc_req), .dbg_halt(dbg_halt),
    .base_wr(base_wr), .base_sel(base_sel), .base_wdata(base_wdata),
    .cfg_wr(cfg_wr), .cfg_ref_en(cfg_ref_en), .cfg_period(cfg_period),
    .acc_stb(acc_stb), .acc_buf(acc_buf), .ref_stb(ref_stb),
    .phys_addr(phys_addr), .row_addr(row_addr)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      bad++;
      total++;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_acc(input int idx, input string tag);
    acc_req = NB'(1) << idx;
    step();
    acc_req = '0;
    chk({tag, " stb"}, 32'(acc_stb), 1);
    chk({tag, " buf"}, 32'(acc_buf), 32'(idx));
    chk({tag, " addr"}, 32'(phys_addr), 32'(mdl[idx]));
    chk({tag, " row"}, 32'(row_addr), 32'(mdl[idx][RW-1:0]));
    mdl[idx] = mdl[idx] + AW'(1);
  endtask

  task automatic write_base(input int idx, input logic [AW-1:0] v);
    base_wr = 1'b1; base_sel = IW'(idx); base_wdata = v;
    step();
    base_wr = 1'b0;
    mdl[idx] = v;
  endtask

  task automatic write_cfg(input logic en, input logic [TW-1:0] p);
    cfg_wr = 1'b1; cfg_ref_en = en; cfg_period = p;
    step();
    cfg_wr = 1'b0;
    step();
  endtask

  task automatic t_reset();
    chk("R1 acc_stb", 32'(acc_stb), 0);
    chk("R1 ref_stb", 32'(ref_stb), 0);
    chk("R1 phys", 32'(phys_addr), 0);
    chk("R1 row", 32'(row_addr), 0);
    chk("R1 buf", 32'(acc_buf), 0);
  endtask

  task automatic t_single();
    do_acc(0, "R1 R2 buf0 first");
    do_acc(1, "R1 R2 buf1 first");
    do_acc(0, "R3 buf0 second");
  endtask

  task automatic t_priority();
    acc_req = '1;
    step();
    acc_req = '0;
    chk("R4 stb", 32'(acc_stb), 1);
    chk("R4 buf", 32'(acc_buf), 0);
    chk("R4 addr", 32'(phys_addr), 32'(mdl[0]));
    mdl[0] = mdl[0] + AW'(1);
    step();
    chk("R4 idle", 32'(acc_stb), 0);
    do_acc(1, "R4 loser unchanged");
  endtask

  task automatic t_base_write();
    base_wr = 1'b1; base_sel = 1'b1; base_wdata = '1; acc_req = 2'b10;
    step();
    base_wr = 1'b0; acc_req = '0;
    mdl[1] = '1;
    chk("R5 blocked", 32'(acc_stb), 0);
    do_acc(1, "R5 loaded");
    do_acc(1, "R3 wrap");
    chk("R3 wrap zero", 32'(mdl[1]), 1);
  endtask

  task automatic t_debug_ignore();
    dbg_halt = 1'b1; acc_req = '1;
    for (int k = 0; k < 6; k++) begin
      step();
      chk("R6 no acc in debug", 32'(acc_stb), 0);
      chk("R7 no ref when disabled", 32'(ref_stb), 0);
    end
    dbg_halt = 1'b0; acc_req = '0;
    step();
    chk("R6 idle after debug", 32'(acc_stb), 0);
    do_acc(0, "R6 base kept buf0");
    do_acc(1, "R6 base kept buf1");
  endtask

  task automatic t_normal_cover();
    for (int r = 0; r < NROW; r++) seen[r] = 0;
    write_base(0, AW'('h1000));
    write_base(1, AW'('h2100));
    for (int n = 0; n < NROW / NB; n++) begin
      for (int b = 0; b < NB; b++) begin
        acc_req = NB'(1) << b;
        step();
        acc_req = '0;
        chk("R11 acc stb", 32'(acc_stb), 1);
        chk("R10 exclusive", 32'(acc_stb & ref_stb), 0);
        chk("R2 addr", 32'(phys_addr), 32'(mdl[b]));
        seen[row_addr] = 1;
        mdl[b] = mdl[b] + AW'(1);
      end
    end
    begin
      int miss = 0;
      for (int r = 0; r < NROW; r++) if (!seen[r]) miss++;
      chk("R11 traffic coverage misses", 32'(miss), 0);
    end
  endtask

  task automatic t_refresh();
    int per = 3;
    for (int r = 0; r < NROW; r++) seen[r] = 0;
    write_cfg(1'b1, TW'(per));
    dbg_halt = 1'b1; acc_req = '1;
    for (int k = 1; k <= 520 * (per + 1); k++) begin
      step();
      chk("R8 strobe timing", 32'(ref_stb), 32'((k % (per + 1)) == 0));
      chk("R10 no acc during refresh", 32'(acc_stb), 0);
      if (ref_stb) begin
        chk("R9 row", 32'(row_addr), 32'(exp_row));
        chk("R7 phys", 32'(phys_addr), 32'(exp_row));
        seen[row_addr] = 1;
        exp_row = exp_row + RW'(1);
      end
    end
    begin
      int miss = 0;
      for (int r = 0; r < NROW; r++) if (!seen[r]) miss++;
      chk("R11 refresh coverage misses", 32'(miss), 0);
    end
    dbg_halt = 1'b0; acc_req = '0;
    for (int k = 0; k < 8; k++) begin
      step();
      chk("R7 no ref outside debug", 32'(ref_stb), 0);
    end
    write_cfg(1'b0, TW'(per));
    dbg_halt = 1'b1;
    for (int k = 0; k < 10; k++) begin
      step();
      chk("R7 no ref when disabled", 32'(ref_stb), 0);
    end
    dbg_halt = 1'b0;
    write_cfg(1'b1, TW'(per));
    dbg_halt = 1'b1;
    for (int k = 1; k <= per + 1; k++) begin
      step();
      chk("R8 R9 resumed strobe", 32'(ref_stb), 32'(k == per + 1));
    end
    chk("R9 row continues", 32'(row_addr), 32'(exp_row));
    dbg_halt = 1'b0;
    step();
  endtask

  initial begin
    mdl[0] = AW'(0);
    mdl[1] = AW'(NROW / NB);
    repeat (3) step();
    rst = 1'b0;
    t_reset();
    step();
    t_single();
    t_priority();
    t_base_write();
    t_debug_ignore();
    t_normal_cover();
    t_refresh();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule